// File: doc/BRIEF.md
# GPI Key-Event Recorder

This block watches eighteen general-purpose input lines, eight row lines and ten column lines, and turns their activity into entries for a key-event queue. Each line has its own programmable active level. Each line also keeps a flag that holds its current state, released or pressed. A released line that reaches its active level produces a press entry. A pressed line that goes back to the opposite level produces a release entry. An entry is one byte. The top bit marks a press or a release, and the low seven bits hold the line's fixed event code.

Before a line can produce an entry, it must pass two gates. The first is a per-line event enable. The second is a keypad-lock filter. While the keypad is locked, this filter blocks every line whose lock-mask bit is set. It blocks all lines when the global lock-all bit is set. A line that is not allowed to record does not produce an entry. Its flag simply follows the line's level. This way the line does not log a stale event later, when it is allowed to record again.

When several lines are pending together, they are recorded one per clock, lowest code first. Entries go into a small queue and leave through a valid/ready stream. When the queue is full, a new entry is dropped and a sticky overflow flag is set. Every recorded entry raises a key-event interrupt flag, which the host clears with a one-cycle pulse. The inputs are expected to be already synchronised and debounced.

Top module: `gpi_event_rec`

## Requirements
- R1: Line i carries event code 97+i. Lines 0..7 are rows, with codes 97..104. Lines 8..17 are columns, with codes 105..114. An entry is `{flag, code[6:0]}`.
- R2: Line i reaches its active level while its flag is released. This records a press entry, with bit 7 = 1. The active level is high when `cfg_act_high[i]`=1 and low when it is 0.
- R3: After a press is recorded, the line is armed only for the opposite level. Reaching that level records a release entry, with bit 7 = 0.
- R4: A line with `cfg_evt_en[i]`=0 records nothing. Its flag follows its level.
- R5: While `lock_on`=1, a line records nothing if its `cfg_lock_mask[i]`=1. All lines record nothing if `lock_all`=1. A blocked line's flag follows its level.
- R6: At most one entry is taken per clock edge, the lowest pending line first. An input present before edge k is visible on `ev_data` after edge k if that line is the lowest pending and the queue is empty.
- R7: Entries leave in arrival order. `ev_valid` is high whenever the queue is not empty. An entry is removed on an edge where `ev_valid` and `ev_ready` are both high. While `ev_valid`=1 and `ev_ready`=0, `ev_data` holds steady.
- R8: `ev_count` equals the number of queued entries. It goes up by one per recorded entry and down by one per removal.
- R9: A line may be taken at an edge where `ev_count`=DEPTH (10), even if a removal happens at the same edge. In that case its entry is dropped, the line's flag still changes, and `ev_overflow` sets. `ev_overflow` stays set until `ovf_clr` is pulsed. A set at the same edge wins over the clear.
- R10: `ev_irq` sets on every recorded entry and clears on an `irq_clr` pulse. A set at the same edge wins over the clear.
- R11: After reset, `ev_valid`=0, `ev_count`=0, `ev_overflow`=0 and `ev_irq`=0, and every flag is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpi_level | input | 18 | Line levels; bits 0..7 rows, 8..17 columns |
| cfg_act_high | input | 18 | Active level per line, 1 = high |
| cfg_evt_en | input | 18 | Per-line event enable |
| cfg_lock_mask | input | 18 | Per-line block while locked |
| lock_on | input | 1 | Keypad locked |
| lock_all | input | 1 | Block all lines while locked |
| ev_valid | output | 1 | Queue head available |
| ev_ready | input | 1 | Consumer takes head |
| ev_data | output | 8 | Head entry {press, code} |
| ev_count | output | 4 | Entries queued |
| ev_overflow | output | 1 | Sticky drop flag |
| ovf_clr | input | 1 | Clear overflow pulse |
| ev_irq | output | 1 | Key-event interrupt flag |
| irq_clr | input | 1 | Clear interrupt pulse |

## Verification
The bench uses the default parameters: eight rows, ten columns, a ten-entry queue and code base 97. With these values, both ends of the code range can be reached, and the ten-entry queue fills after ten presses while it is stalled. This lets directed steps reach the overflow drop and check the first and last codes exactly. Random line toggles, changing configuration, lock states and ready patterns then exercise same-cycle contention and flag tracking against a reference model kept in the bench.

// File: rtl/gpi_ev_pkg.sv
package gpi_ev_pkg;
  localparam int unsigned CODE_W = 7;
  localparam int unsigned ENTRY_W = CODE_W + 1;
  typedef logic [ENTRY_W-1:0] ev_entry_t;

  function automatic logic [CODE_W-1:0] line_code(input int unsigned base, input int unsigned idx);
    return CODE_W'(base + idx);
  endfunction
endpackage

// File: rtl/gpi_line_track.sv
module gpi_line_track (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic rec_ok,
  input  logic grant,
  output logic pend,
  output logic pressed
);
  assign pend = rec_ok & (act ^ pressed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pressed <= 1'b0;
    else if (!rec_ok) pressed <= act;
    else if (grant) pressed <= ~pressed;
  end

  // R3: a taken line flips its flag
  a_r3_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && rec_ok) |=> (pressed != $past(pressed)));
  // R4/R5: blocked line follows its level
  a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_ok) |=> (pressed == $past(act)));
endmodule

// File: rtl/gpi_pick.sv
module gpi_pick #(
  parameter int unsigned N = 18,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic [IW-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_gnt
    assign grant[g] = any && (idx == IW'(g));
  end

  // R6: one line per edge, and only a requesting one
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (((req & (grant - 1'b1)) == '0) && ((req & grant) != '0)));
endmodule

// File: rtl/gpi_ev_fifo.sv
module gpi_ev_fifo
  import gpi_ev_pkg::*;
#(
  parameter int unsigned DEPTH = 10,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  ev_entry_t wdata,
  output logic      full,
  output logic      valid,
  input  logic      ready,
  output ev_entry_t rdata,
  output logic [CW-1:0] count
);
  ev_entry_t mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic pop;

  assign valid = (count != '0);
  assign full  = (count == CW'(DEPTH));
  assign pop   = valid & ready;
  assign rdata = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop) count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  // R7: head holds while stalled
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(rdata)));
  // R8: never beyond depth, never a push into a full queue
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH));
  a_r9_no_overfill: assert property (@(posedge clk) disable iff (!rst_n) !(push && full));
endmodule

// File: rtl/gpi_event_rec.sv
module gpi_event_rec
  import gpi_ev_pkg::*;
#(
  parameter int unsigned N_ROWS = 8,
  parameter int unsigned N_COLS = 10,
  parameter int unsigned DEPTH = 10,
  parameter int unsigned CODE_BASE = 97,
  localparam int unsigned N = N_ROWS + N_COLS,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  gpi_level,
  input  logic [N-1:0]  cfg_act_high,
  input  logic [N-1:0]  cfg_evt_en,
  input  logic [N-1:0]  cfg_lock_mask,
  input  logic          lock_on,
  input  logic          lock_all,
  output logic          ev_valid,
  input  logic          ev_ready,
  output logic [7:0]    ev_data,
  output logic [CW-1:0] ev_count,
  output logic          ev_overflow,
  input  logic          ovf_clr,
  output logic          ev_irq,
  input  logic          irq_clr
);
  logic [N-1:0] act, rec_ok, pend, grant, pressed;
  logic [IW-1:0] pick_idx;
  logic pick_any, full, push;
  ev_entry_t entry, head;

  assign act    = ~(gpi_level ^ cfg_act_high);
  assign rec_ok = cfg_evt_en & ~({N{lock_on}} & (cfg_lock_mask | {N{lock_all}}));

  for (genvar g = 0; g < N; g++) begin : g_line
    gpi_line_track u_trk (
      .clk(clk), .rst_n(rst_n), .act(act[g]), .rec_ok(rec_ok[g]),
      .grant(grant[g]), .pend(pend[g]), .pressed(pressed[g])
    );
  end

  gpi_pick #(.N(N)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(pend), .grant(grant), .idx(pick_idx), .any(pick_any)
  );

  assign entry = {~pressed[pick_idx], line_code(CODE_BASE, int'(pick_idx))};
  assign push  = pick_any & ~full;

  gpi_ev_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(entry), .full(full),
    .valid(ev_valid), .ready(ev_ready), .rdata(head), .count(ev_count)
  );
  assign ev_data = head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_overflow <= 1'b0;
      ev_irq      <= 1'b0;
    end else begin
      ev_overflow <= (pick_any & full) | (ev_overflow & ~ovf_clr);
      ev_irq      <= push | (ev_irq & ~irq_clr);
    end
  end

  // R9: drop on full sets overflow
  a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_any && full) |=> ev_overflow);
  // R10: a recorded entry raises the interrupt
  a_r10_irq_set: assert property (@(posedge clk) disable iff (!rst_n) push |=> ev_irq);
  // R8: count rises on a lone push
  a_r8_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !(ev_valid && ev_ready)) |=> (ev_count == $past(ev_count) + 1'b1));
endmodule

// File: tb/gpi_event_rec_test.sv
module gpi_event_rec_test;
  localparam int N = 18;
  localparam int DEPTH = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] gpi_level = '0, cfg_act_high = '1, cfg_evt_en = '0, cfg_lock_mask = '0;
  logic lock_on = 0, lock_all = 0, ev_ready = 0, ovf_clr = 0, irq_clr = 0;
  logic ev_valid, ev_overflow, ev_irq;
  logic [7:0] ev_data;
  logic [3:0] ev_count;

  int checks = 0, fails = 0, cycles = 0;

  gpi_event_rec uut (
    .clk(clk), .rst_n(rst_n), .gpi_level(gpi_level), .cfg_act_high(cfg_act_high),
    .cfg_evt_en(cfg_evt_en), .cfg_lock_mask(cfg_lock_mask), .lock_on(lock_on),
    .lock_all(lock_all), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_data(ev_data),
    .ev_count(ev_count), .ev_overflow(ev_overflow), .ovf_clr(ovf_clr),
    .ev_irq(ev_irq), .irq_clr(irq_clr)
  );

  always #2.5 clk = ~clk;

  // reference model
  logic [N-1:0] m_pr = '0;
  logic [7:0] mq [16];
  int m_cnt = 0;
  logic m_ovf = 0, m_irq = 0;

  function automatic logic [6:0] code_of(input int i);
    return 7'(97 + i);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [N-1:0] act, rok;
    int pick;
    logic pushed;
    logic was_full;
    act = ~(gpi_level ^ cfg_act_high);
    rok = cfg_evt_en & ~({N{lock_on}} & (cfg_lock_mask | {N{lock_all}}));
    was_full = (m_cnt == DEPTH);
    pick = -1;
    for (int i = 0; i < N; i++)
      if (pick < 0 && rok[i] && (act[i] != m_pr[i])) pick = i;
    if (ev_ready && m_cnt > 0) begin
      for (int k = 0; k < 15; k++) mq[k] = mq[k+1];
      m_cnt--;
    end
    pushed = 0;
    if (pick >= 0) begin
      if (was_full) m_ovf = 1;
      else begin
        mq[m_cnt] = {~m_pr[pick], code_of(pick)};
        m_cnt++;
        pushed = 1;
      end
    end
    else if (ovf_clr) m_ovf = 0;
    if (pick >= 0 && !was_full && ovf_clr) m_ovf = 0;
    m_irq = pushed | (m_irq & ~irq_clr);
    for (int i = 0; i < N; i++) begin
      if (!rok[i]) m_pr[i] = act[i];
      else if (i == pick) m_pr[i] = ~m_pr[i];
    end
  endtask

  task automatic compare();
    chk(ev_valid == (m_cnt != 0), "R7 valid", ev_valid, m_cnt != 0);
    if (m_cnt != 0) chk(ev_data == mq[0], "R1/R2/R3 data", ev_data, mq[0]);
    chk(ev_count == 4'(m_cnt), "R8 count", ev_count, m_cnt);
    chk(ev_overflow == m_ovf, "R9 overflow", ev_overflow, m_ovf);
    chk(ev_irq == m_irq, "R10 irq", ev_irq, m_irq);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compare();
    ovf_clr = 0;
    irq_clr = 0;
  endtask

  task automatic drain();
    ev_ready = 1;
    for (int k = 0; k < 14; k++) tick();
    ev_ready = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!ev_valid && ev_count == 0 && !ev_overflow && !ev_irq, "R11 reset", ev_count, 0);
    rst_n = 1;
    @(negedge clk);
    cfg_evt_en = '1;
    tick();

    // R2 press on row 0, active high
    gpi_level[0] = 1; tick();
    chk(ev_data == 8'hE1, "R2 press row0", ev_data, 8'hE1);
    // R3 release
    gpi_level[0] = 0; tick();
    chk(ev_count == 2, "R8 two entries", ev_count, 2);
    ev_ready = 1; tick(); ev_ready = 0;
    chk(ev_data == 8'h61, "R3 release row0", ev_data, 8'h61);
    drain();

    // R1 last column, active low
    gpi_level[17] = 1; cfg_act_high[17] = 0; tick();
    gpi_level[17] = 0; tick();
    chk(ev_data == 8'hF2, "R1 column9 code 114", ev_data, 8'hF2);
    irq_clr = 1; tick();
    chk(!ev_irq, "R10 irq cleared", ev_irq, 0);
    drain();

    // R6 same-cycle contention: lines 12 and 5
    gpi_level[12] = 1; gpi_level[5] = 1; tick();
    chk(ev_data == 8'hE6 && ev_count == 1, "R6 lowest first", ev_data, 8'hE6);
    tick();
    chk(ev_count == 2, "R6 one per edge", ev_count, 2);
    drain();

    // R4 disabled line
    cfg_evt_en[4] = 0; gpi_level[4] = 1; tick(); tick();
    chk(ev_count == 0, "R4 disabled silent", ev_count, 0);
    cfg_evt_en[4] = 1; tick();
    chk(ev_count == 0, "R4 no stale event", ev_count, 0);

    // R5 lock with mask, and lock_all
    lock_on = 1; cfg_lock_mask[3] = 1; gpi_level[3] = 1; tick();
    chk(ev_count == 0, "R5 masked line", ev_count, 0);
    gpi_level[6] = 1; tick();
    chk(ev_count == 1, "R5 unmasked line logs", ev_count, 1);
    lock_all = 1; gpi_level[7] = 1; tick();
    chk(ev_count == 1, "R5 lock_all blocks", ev_count, 1);
    lock_on = 0; lock_all = 0; cfg_lock_mask = '0;
    drain();

    // R9 overflow with stalled consumer
    gpi_level = '0; tick(); drain();
    for (int k = 0; k < 11; k++) begin gpi_level[k] = 1; tick(); end
    chk(ev_count == 10 && ev_overflow, "R9 full drop", ev_count, 10);
    ovf_clr = 1; tick();
    chk(!ev_overflow, "R9 ovf cleared", ev_overflow, 0);
    drain();

    // random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(7) == 0) gpi_level[$urandom_range(N-1)] ^= 1'b1;
      if ($urandom_range(63) == 0) cfg_act_high[$urandom_range(N-1)] ^= 1'b1;
      if ($urandom_range(63) == 0) cfg_evt_en[$urandom_range(N-1)] ^= 1'b1;
      if ($urandom_range(63) == 0) cfg_lock_mask[$urandom_range(N-1)] ^= 1'b1;
      if ($urandom_range(127) == 0) lock_on = ~lock_on;
      if ($urandom_range(255) == 0) lock_all = ~lock_all;
      ev_ready = ($urandom_range(3) != 0) ? (c % 400 < 300) : 1'b0;
      ovf_clr = ($urandom_range(31) == 0);
      irq_clr = ($urandom_range(15) == 0);
      tick();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule